// File: doc/BRIEF.md
# Parallel String Membership Matcher

The block keeps a small table of sixteen-byte ASCII strings and answers, one cycle after being asked, whether a query string equals any of them. Every table entry has its own full-width equality comparator, and all comparators see the same query, so one lookup costs one cycle whatever the table holds.

Reset fills the table from a parameter array and points the write pointer at entry 0. After that, each accepted push overwrites the entry that has been in the table longest, in circular order. The lookup result is registered and carries a valid strobe, an any-match flag and one match bit per entry.

Top module: `string_set_matcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, `res_any` and `res_vec` are all 0.
- R2: After reset, entry i holds slice i of the `INIT_TABLE` parameter (bits i*128 upward); by default every byte of entry i is ASCII 0x41+i, so a query of sixteen 0x41 bytes sets `res_vec` bit 0.
- R3: `res_valid` is 1 in exactly the cycle after a cycle with `qry_valid` high, and 0 after any cycle with `qry_valid` low.
- R4: `res_vec` bit i is 1 exactly when the query equals entry i in all 128 bits; a query that differs from an entry in any single bit does not match it.
- R5: `res_any` equals the OR of the bits of `res_vec`.
- R6: Pushes replace entries oldest-first: the first push after reset writes entry 0, then entries 1, 2 and 3, and the fifth push writes entry 0 again.
- R7: A query in the same cycle as a push is compared against the table contents from before that push.
- R8: A reset after pushes restores every entry to its `INIT_TABLE` value and sends the next push to entry 0.
- R9: When several entries hold the same string, a query of that string sets all of their `res_vec` bits together.
- R10: Cycles without a push leave the table unchanged, and `res_any`/`res_vec` keep the last result while no query arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Write `push_str` into the oldest entry |
| push_str | input | 128 | String to store, sixteen bytes |
| qry_valid | input | 1 | Compare `qry_str` with all entries |
| qry_str | input | 128 | Query string, sixteen bytes |
| res_valid | output | 1 | Result strobe, one cycle after a query |
| res_any | output | 1 | Query equals at least one entry |
| res_vec | output | 4 | Per-entry match bits, bit i for entry i |

## Verification
The assertions watch, on every cycle, that the result strobe follows the query strobe by one cycle, that the any-match flag agrees with the match vector, that the write pointer stays in range and steps circularly only on a push, and that a pushed string lands in the slot the pointer named. Which entry actually matches a given query, the oldest-first replacement order over many pushes, the pre-push view of a simultaneous push and query, and the restore of contents on a second reset can only be shown by the bench, which keeps its own model of the table and sweeps every single-bit difference against a stored entry.

// File: rtl/strmatch_pkg.sv
package strmatch_pkg;

    localparam int STR_BYTES = 16;
    localparam int STR_W     = STR_BYTES * 8;
    localparam int N_ENTRIES = 4;
    localparam int TABLE_W   = N_ENTRIES * STR_W;

    typedef logic [STR_W-1:0]     str_t;
    typedef logic [N_ENTRIES-1:0] hitvec_t;

    typedef struct packed {
        logic    valid;
        logic    any;
        hitvec_t vec;
    } match_res_t;

    // Entry i: every byte is 'A' + i.
    function automatic logic [TABLE_W-1:0] default_table();
        logic [TABLE_W-1:0] t;
        t = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            for (int b = 0; b < STR_BYTES; b++) begin
                t[i*STR_W + b*8 +: 8] = 8'(8'h41 + i);
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/strmatch_store.sv
module strmatch_store #(
    parameter int N = 4,
    parameter int W = 128,
    parameter logic [N*W-1:0] INIT = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [W-1:0]   wr_data,
    output logic [N*W-1:0] table_q
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    logic [W-1:0]     slot [N];
    logic [PTR_W-1:0] wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
        end else if (wr_en) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= INIT[i*W +: W];
            end else if (wr_en && (wptr == PTR_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
        assign table_q[i*W +: W] = slot[i];
    end

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wptr <= LAST);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wptr));

    // R6
    slot_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot[$past(wptr)] == $past(wr_data));

endmodule

// File: rtl/strmatch_cmp.sv
module strmatch_cmp #(
    parameter int N = 4,
    parameter int W = 128
) (
    input  logic [N*W-1:0] table_q,
    input  logic [W-1:0]   query,
    output logic [N-1:0]   eq
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = (table_q[i*W +: W] == query);
    end
endmodule

// File: rtl/string_set_matcher.sv
module string_set_matcher
    import strmatch_pkg::*;
#(
    parameter logic [TABLE_W-1:0] INIT_TABLE = default_table()
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_valid,
    input  logic [STR_W-1:0]     push_str,
    input  logic                 qry_valid,
    input  logic [STR_W-1:0]     qry_str,
    output logic                 res_valid,
    output logic                 res_any,
    output logic [N_ENTRIES-1:0] res_vec
);
    logic [TABLE_W-1:0] table_q;
    hitvec_t            eq;
    match_res_t         res_q;

    strmatch_store #(.N(N_ENTRIES), .W(STR_W), .INIT(INIT_TABLE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push_valid),
        .wr_data (push_str),
        .table_q (table_q)
    );

    strmatch_cmp #(.N(N_ENTRIES), .W(STR_W)) u_cmp (
        .table_q (table_q),
        .query   (qry_str),
        .eq      (eq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= qry_valid;
            if (qry_valid) begin
                res_q.any <= |eq;
                res_q.vec <= eq;
            end
        end
    end

    assign res_valid = res_q.valid;
    assign res_any   = res_q.any;
    assign res_vec   = res_q.vec;

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        qry_valid |=> res_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !qry_valid |=> !res_valid);

    // R5
    any_or_chk: assert property (@(posedge clk) disable iff (rst)
        res_any == (res_vec != '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !qry_valid |=> $stable(res_vec) && $stable(res_any));

endmodule

// File: tb/string_set_matcher_tb.sv
module string_set_matcher_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 128;
    localparam int N = 4;

    logic         clk = 0;
    logic         rst = 1;
    logic         push_valid = 0;
    logic [W-1:0] push_str = '0;
    logic         qry_valid = 0;
    logic [W-1:0] qry_str = '0;
    logic         res_valid;
    logic         res_any;
    logic [N-1:0] res_vec;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model [N];
    int           mptr;
    logic [N-1:0] last_vec;
    logic         last_any;

    always #(CLK_PERIOD/2) clk = ~clk;

    string_set_matcher u_dut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_str(push_str),
        .qry_valid(qry_valid), .qry_str(qry_str),
        .res_valid(res_valid), .res_any(res_any), .res_vec(res_vec)
    );

    function automatic logic [W-1:0] fill(input logic [7:0] b);
        return {16{b}};
    endfunction

    function automatic logic [N-1:0] exp_vec(input logic [W-1:0] q);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (model[i] == q);
        return v;
    endfunction

    task automatic check(input string tag, input logic ev, input logic ea, input logic [N-1:0] evec);
        checks++;
        if (res_valid !== ev || res_any !== ea || res_vec !== evec) begin
            failures++;
            $display("FAIL %s: got valid=%b any=%b vec=%b, expected valid=%b any=%b vec=%b",
                     tag, res_valid, res_any, res_vec, ev, ea, evec);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) model[i] = fill(8'(8'h41 + i));
        mptr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; push_valid = 0; qry_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        last_vec = '0; last_any = 0;
    endtask

    // One cycle with optional push and query; checks the registered result.
    task automatic step(input string tag, input logic p, input logic [W-1:0] pd,
                        input logic q, input logic [W-1:0] qd);
        logic [N-1:0] ev;
        @(negedge clk);
        push_valid = p; push_str = pd; qry_valid = q; qry_str = qd;
        ev = exp_vec(qd);
        if (q) begin last_vec = ev; last_any = |ev; end
        @(posedge clk);
        if (p) begin model[mptr] = pd; mptr = (mptr + 1) % N; end
        #1;
        push_valid = 0; qry_valid = 0;
        check(tag, q, last_any, last_vec);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        last_vec = '0; last_any = 0;
        repeat (2) @(negedge clk);
        #1 check("R1 in reset", 0, 0, '0);
        rst = 0;
        model_reset();
        #1 check("R1 after reset", 0, 0, '0);

        // R2 R4 R5: each initial entry hits its own bit
        for (int i = 0; i < N; i++) step("R2 init entry", 0, '0, 1, fill(8'(8'h41 + i)));
        step("R4 miss", 0, '0, 1, fill(8'h5A));

        // R4: every single-bit difference against entry 2 misses
        for (int b = 0; b < W; b++) begin
            logic [W-1:0] qv;
            qv = fill(8'h43);
            qv[b] = ~qv[b];
            step("R4 single bit flip", 0, '0, 1, qv);
        end

        // R10: idle cycles keep result and contents
        step("R10 idle hold", 0, '0, 0, '0);
        step("R3 valid low when idle", 0, '0, 0, '0);
        step("R10 contents kept", 0, '0, 1, fill(8'h44));

        // R6: oldest-first replacement with wrap
        for (int k = 0; k < 6; k++) begin
            step("R6 push", 1, fill(8'(8'h61 + k)), 0, '0);
            for (int j = 0; j <= k; j++) step("R6 query pushed", 0, '0, 1, fill(8'(8'h61 + j)));
        end

        // R7: simultaneous push and query sees old contents
        step("R7 push+query old", 1, fill(8'h70), 1, fill(8'h70));
        step("R7 new visible", 0, '0, 1, fill(8'h70));
        step("R7 push+query evicted", 1, fill(8'h71), 1, model[mptr]);

        // R9: duplicates give multiple hits
        step("R9 dup push", 1, fill(8'h30), 0, '0);
        step("R9 dup push", 1, fill(8'h30), 0, '0);
        step("R9 dup push", 1, fill(8'h30), 0, '0);
        step("R9 multi hit", 0, '0, 1, fill(8'h30));

        // R8: reset restores contents and pointer
        do_reset();
        #1 check("R1 after second reset", 0, 0, '0);
        for (int i = 0; i < N; i++) step("R8 restored", 0, '0, 1, fill(8'(8'h41 + i)));
        step("R8 push to entry0", 1, fill(8'h7E), 0, '0);
        step("R8 entry0 replaced", 0, '0, 1, fill(8'h7E));
        step("R8 old entry0 gone", 0, '0, 1, fill(8'h41));
        step("R8 entry1 kept", 0, '0, 1, fill(8'h42));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule